// File: doc/BRIEF.md
# Segmented Downward-Growing Stack Controller

This block runs a last-in-first-out stack of 16-bit words that lives in external byte-addressable memory. It keeps a stack segment register and a stack pointer offset. The requester can load both to place the stack anywhere in the physical space, and there is no fixed depth. Every memory access goes to the physical address formed by shifting the segment left by four bits and adding the offset. The sum wraps within the 20-bit space.

The stack grows toward lower addresses. A push decrements the pointer by two and then writes the word at the new location. A pop reads the word at the current location and then increments the pointer by two. Words are stored as two bytes in little-endian order. The external memory sees a request/acknowledge handshake. The pointer is committed only when the acknowledge arrives. Completion is signalled by a one-cycle done pulse, and on a pop this pulse comes with valid read data.

Top module: `stack_seg_ctrl`

## Requirements
- R1: While `memReq` is high, `memAddr` equals (`stackSeg` × 16 + operation offset) modulo 2^20.
- R2: A push accepted while idle drives `memReq`=1, `memWe`=1, `memAddr` formed from `stackPtr`−2, and `memWdata` = the pushed word, whose low byte goes to the even address. `stackPtr` becomes `stackPtr`−2 only after `memAck`.
- R3: A pop accepted while idle drives `memReq`=1, `memWe`=0, and `memAddr` formed from the current `stackPtr`. On `memAck` the read word is returned on `popData` with a one-cycle `popValid`, and `stackPtr` then becomes `stackPtr`+2.
- R4: Successive pushes use strictly decreasing addresses, two apart, and the pops that follow return the words in reverse order of pushing.
- R5: `stackPtr` wraps modulo 65536: a push at offset 0x0000 uses offset 0xFFFE, and a pop at 0xFFFE leaves 0x0000. The physical address wraps modulo 2^20.
- R6: Until `memAck`, `memReq` stays high and `memAddr`, `memWe` and `stackPtr` are held constant.
- R7: `opDone` pulses for exactly one cycle, in the cycle after the acknowledged transfer, for both push and pop.
- R8: `pushReq` and `popReq` high together while idle produce a one-cycle `errConflict` in the next cycle. No memory request is made and the pointer does not change.
- R9: Loads of `stackSeg` and `stackPtr` take effect while idle and win over a push or pop in the same cycle, which is then dropped. Loads and stack requests that arrive while a transfer is in flight are ignored.
- R10: After reset, `stackSeg` and `stackPtr` are zero and `memReq`, `opDone`, `popValid` and `errConflict` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldSegValid | input | 1 | Load stack segment this cycle |
| ldSegData | input | 16 | New stack segment value |
| ldPtrValid | input | 1 | Load stack pointer this cycle |
| ldPtrData | input | 16 | New stack pointer value |
| pushReq | input | 1 | Request a push of `pushData` |
| pushData | input | 16 | Word to push |
| popReq | input | 1 | Request a pop |
| popData | output | 16 | Popped word, valid with `popValid` |
| popValid | output | 1 | One-cycle pop data strobe |
| opDone | output | 1 | One-cycle completion pulse |
| errConflict | output | 1 | One-cycle pulse for a simultaneous push and pop |
| stackSeg | output | 16 | Current stack segment |
| stackPtr | output | 16 | Current stack pointer offset |
| memReq | output | 1 | Memory transfer request |
| memWe | output | 1 | 1 = write (push), 0 = read (pop) |
| memAddr | output | 20 | Physical byte address of the word |
| memWdata | output | 16 | Write word, little-endian |
| memAck | input | 1 | Memory transfer complete |
| memRdata | input | 16 | Read word, valid with `memAck` |

## Verification
The bench builds the block with its default parameters: a 16-bit segment, a 16-bit offset, a 4-bit shift and 16-bit words. At these sizes both wrap points can be reached in a few operations. The offset passes zero after a single push from 0x0000. The 20-bit sum overflows when the segment is 0xFFFF and the offset is a little above 0x000F. The bench memory answers after 0 to 3 wait cycles, so the hold-until-acknowledge rules and the ignoring of requests while busy are exercised with both short and long waits.

// File: rtl/stkPkg.sv
package stkPkg;
  typedef struct packed {
    logic loadSeg;
    logic loadPtr;
    logic startPush;
    logic startPop;
    logic commitOp;
    logic captureRd;
  } stkStrobes_t;

  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_BUS = 1'b1} stkState_t;
endpackage

// File: rtl/stkDatapath.sv
module stkDatapath import stkPkg::*; #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int DATA_W = 16,
  parameter int PHYS_W = SEG_W + SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  stkStrobes_t       strb,
  input  logic [SEG_W-1:0]  ldSegData,
  input  logic [OFF_W-1:0]  ldPtrData,
  input  logic [DATA_W-1:0] pushData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [SEG_W-1:0]  stackSeg,
  output logic [OFF_W-1:0]  stackPtr,
  output logic [PHYS_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] popData
);
  localparam int STEP = DATA_W / 8;

  logic [OFF_W-1:0] ptrDown;
  logic [OFF_W-1:0] ptrUp;
  logic [OFF_W-1:0] nextOff;

  function automatic logic [PHYS_W-1:0] physOf(input logic [SEG_W-1:0] seg,
                                                input logic [OFF_W-1:0] off);
    logic [PHYS_W-1:0] base;
    base = PHYS_W'(seg) << SHIFT;
    return base + PHYS_W'(off);
  endfunction

  assign ptrDown = stackPtr - OFF_W'(STEP);
  assign ptrUp   = stackPtr + OFF_W'(STEP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stackSeg <= '0;
      stackPtr <= '0;
      memAddr  <= '0;
      memWdata <= '0;
      popData  <= '0;
      nextOff  <= '0;
    end else begin
      if (strb.loadSeg) stackSeg <= ldSegData;
      if (strb.loadPtr) stackPtr <= ldPtrData;
      if (strb.startPush) begin
        memAddr  <= physOf(stackSeg, ptrDown);
        memWdata <= pushData;
        nextOff  <= ptrDown;
      end
      if (strb.startPop) begin
        memAddr <= physOf(stackSeg, stackPtr);
        nextOff <= ptrUp;
      end
      if (strb.commitOp)  stackPtr <= nextOff;
      if (strb.captureRd) popData  <= memRdata;
    end
  end

  // R9: a load never coincides with a stack operation start or commit
  assert_load_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadSeg || strb.loadPtr) |-> !(strb.startPush || strb.startPop || strb.commitOp));
endmodule

// File: rtl/stkControl.sv
module stkControl import stkPkg::*; (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ldSegValid,
  input  logic        ldPtrValid,
  input  logic        pushReq,
  input  logic        popReq,
  input  logic        memAck,
  output stkStrobes_t strb,
  output logic        memReq,
  output logic        memWe,
  output logic        opDone,
  output logic        popValid,
  output logic        errConflict
);
  stkState_t state;
  logic      isIdle;
  logic      anyLoad;
  logic      bothReq;
  logic      finish;

  assign isIdle  = (state == ST_IDLE);
  assign anyLoad = ldSegValid || ldPtrValid;
  assign bothReq = pushReq && popReq;
  assign finish  = (state == ST_BUS) && memAck;

  always_comb begin
    strb           = '0;
    strb.loadSeg   = isIdle && ldSegValid;
    strb.loadPtr   = isIdle && ldPtrValid;
    strb.startPush = isIdle && !anyLoad && pushReq && !popReq;
    strb.startPop  = isIdle && !anyLoad && popReq && !pushReq;
    strb.commitOp  = finish;
    strb.captureRd = finish && !memWe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      memReq      <= 1'b0;
      memWe       <= 1'b0;
      opDone      <= 1'b0;
      popValid    <= 1'b0;
      errConflict <= 1'b0;
    end else begin
      opDone      <= finish;
      popValid    <= finish && !memWe;
      errConflict <= isIdle && !anyLoad && bothReq;
      case (state)
        ST_IDLE: begin
          if (strb.startPush || strb.startPop) begin
            state  <= ST_BUS;
            memReq <= 1'b1;
            memWe  <= strb.startPush;
          end
        end
        ST_BUS: begin
          if (memAck) begin
            state  <= ST_IDLE;
            memReq <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    opDone |=> !opDone);
  assert_popvalid_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    popValid |-> opDone);
  assert_conflict_noreq_R8: assert property (@(posedge clk) disable iff (!rstN)
    errConflict |-> (!memReq && !opDone));
endmodule

// File: rtl/stack_seg_ctrl.sv
module stack_seg_ctrl import stkPkg::*; #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int DATA_W = 16,
  localparam int PHYS_W = SEG_W + SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldSegValid,
  input  logic [SEG_W-1:0]  ldSegData,
  input  logic              ldPtrValid,
  input  logic [OFF_W-1:0]  ldPtrData,
  input  logic              pushReq,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popReq,
  output logic [DATA_W-1:0] popData,
  output logic              popValid,
  output logic              opDone,
  output logic              errConflict,
  output logic [SEG_W-1:0]  stackSeg,
  output logic [OFF_W-1:0]  stackPtr,
  output logic              memReq,
  output logic              memWe,
  output logic [PHYS_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata
);
  localparam int STEP = DATA_W / 8;

  stkStrobes_t strb;

  stkControl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ldSegValid (ldSegValid),
    .ldPtrValid (ldPtrValid),
    .pushReq    (pushReq),
    .popReq     (popReq),
    .memAck     (memAck),
    .strb       (strb),
    .memReq     (memReq),
    .memWe      (memWe),
    .opDone     (opDone),
    .popValid   (popValid),
    .errConflict(errConflict)
  );

  stkDatapath #(
    .SEG_W (SEG_W),
    .OFF_W (OFF_W),
    .SHIFT (SHIFT),
    .DATA_W(DATA_W),
    .PHYS_W(PHYS_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .ldSegData(ldSegData),
    .ldPtrData(ldPtrData),
    .pushData (pushData),
    .memRdata (memRdata),
    .stackSeg (stackSeg),
    .stackPtr (stackPtr),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .popData  (popData)
  );

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));
  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> $stable(stackPtr));
  assert_push_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (opDone && !popValid) |-> (stackPtr == $past(stackPtr) - OFF_W'(STEP)));
  assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    popValid |-> (stackPtr == $past(stackPtr) + OFF_W'(STEP)));
endmodule

// File: tb/test_stack_seg_ctrl.sv
module test_stack_seg_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ldSegValid = 0, ldPtrValid = 0, pushReq = 0, popReq = 0;
  logic [15:0] ldSegData = 0, ldPtrData = 0, pushData = 0;
  logic [15:0] popData, stackSeg, stackPtr, memWdata;
  logic        popValid, opDone, errConflict, memReq, memWe;
  logic [19:0] memAddr;
  logic        memAck = 1'b0;
  logic [15:0] memRdata = 16'h0;

  int nChecks = 0;
  int nErr = 0;
  int memLat = 0;
  int waitCnt = 0;
  bit finished = 0;
  logic [7:0] mem [int];

  always #10 clk = ~clk;

  stack_seg_ctrl i_stack_seg_ctrl (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rdByte(input int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  // memory responder
  always @(negedge clk) begin
    if (memAck) begin
      memAck = 1'b0;
      waitCnt = 0;
    end else if (memReq) begin
      if (waitCnt >= memLat) begin
        memAck = 1'b1;
        if (memWe) begin
          mem[int'(memAddr)] = memWdata[7:0];
          mem[(int'(memAddr) + 1) & 32'hFFFFF] = memWdata[15:8];
        end else begin
          memRdata = {rdByte((int'(memAddr) + 1) & 32'hFFFFF), rdByte(int'(memAddr))};
        end
      end else waitCnt++;
    end
  end

  // behavioural reference model
  int  mSeg, mPtr, mAddr, mWdata, mNext, ePopData;
  bit  mBusy, mWe, eDone, ePopV, eErr;
  always @(posedge clk) begin
    if (!rstN) begin
      mSeg = 0; mPtr = 0; mBusy = 0; mWe = 0; eDone = 0; ePopV = 0; eErr = 0;
    end else begin
      eDone = 0; ePopV = 0; eErr = 0;
      if (mBusy) begin
        if (memAck) begin
          mPtr = mNext;
          if (!mWe) begin ePopV = 1; ePopData = int'(memRdata); end
          eDone = 1;
          mBusy = 0;
        end
      end else if (ldSegValid || ldPtrValid) begin
        if (ldSegValid) mSeg = int'(ldSegData);
        if (ldPtrValid) mPtr = int'(ldPtrData);
      end else if (pushReq && popReq) begin
        eErr = 1;
      end else if (pushReq) begin
        mBusy = 1; mWe = 1; mWdata = int'(pushData);
        mNext = (mPtr - 2) & 32'hFFFF;
        mAddr = (mSeg * 16 + mNext) & 32'hFFFFF;
      end else if (popReq) begin
        mBusy = 1; mWe = 0;
        mNext = (mPtr + 2) & 32'hFFFF;
        mAddr = (mSeg * 16 + mPtr) & 32'hFFFFF;
      end
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R6", "memReq", 32'(memReq), 32'(mBusy));
      chk("R9", "stackSeg", 32'(stackSeg), mSeg);
      chk("R5", "stackPtr", 32'(stackPtr), mPtr);
      chk("R7", "opDone", 32'(opDone), 32'(eDone));
      chk("R3", "popValid", 32'(popValid), 32'(ePopV));
      chk("R8", "errConflict", 32'(errConflict), 32'(eErr));
      if (memReq && mBusy) begin
        chk("R1", "memAddr", 32'(memAddr), mAddr);
        chk("R2", "memWe", 32'(memWe), 32'(mWe));
        if (mWe) chk("R2", "memWdata", 32'(memWdata), mWdata);
      end
      if (popValid) chk("R3", "popData", 32'(popData), ePopData);
    end
  end

  task automatic loadRegs(input bit dS, input logic [15:0] s, input bit dP, input logic [15:0] p);
    @(negedge clk);
    ldSegValid = dS; ldSegData = s; ldPtrValid = dP; ldPtrData = p;
    @(negedge clk);
    ldSegValid = 0; ldPtrValid = 0;
  endtask

  task automatic doPush(input logic [15:0] v, output logic [19:0] a);
    @(negedge clk);
    pushReq = 1; pushData = v;
    @(negedge clk);
    pushReq = 0;
    a = memAddr;
    while (!opDone) @(negedge clk);
  endtask

  task automatic doPop(output logic [15:0] v, output logic [19:0] a);
    @(negedge clk);
    popReq = 1;
    @(negedge clk);
    popReq = 0;
    a = memAddr;
    while (!opDone) @(negedge clk);
    v = popData;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nErr++; nChecks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    logic [19:0] a0, a1, a2, pa;
    logic [15:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", "reset seg", 32'(stackSeg), 0);
    chk("R10", "reset ptr", 32'(stackPtr), 0);
    chk("R10", "reset memReq", 32'(memReq), 0);
    chk("R10", "reset opDone", 32'(opDone), 0);
    rstN = 1;

    // R9 load both
    loadRegs(1, 16'h1000, 1, 16'h0100);
    chk("R9", "seg load", 32'(stackSeg), 32'h1000);
    chk("R9", "ptr load", 32'(stackPtr), 32'h0100);

    // R2 push, little-endian
    memLat = 0;
    doPush(16'hA1B2, a0);
    chk("R2", "push addr", 32'(a0), 32'h100FE);
    chk("R2", "ptr after push", 32'(stackPtr), 32'h00FE);
    chk("R2", "low byte", 32'(rdByte(32'h100FE)), 32'hB2);
    chk("R2", "high byte", 32'(rdByte(32'h100FF)), 32'hA1);
    @(negedge clk);
    chk("R7", "done one cycle", 32'(opDone), 0);

    // R4 successive pushes
    memLat = 2;
    doPush(16'h1111, a0);
    doPush(16'h2222, a1);
    memLat = 1;
    doPush(16'h3333, a2);
    chk("R4", "push addr step 1", 32'(a0 - a1), 2);
    chk("R4", "push addr step 2", 32'(a1 - a2), 2);

    // R6 hold during wait, R3/R4 LIFO pops
    memLat = 3;
    @(negedge clk); popReq = 1;
    @(negedge clk); popReq = 0; pa = memAddr;
    @(negedge clk);
    chk("R6", "ptr held while waiting", 32'(stackPtr), 32'h00F8);
    chk("R6", "req held", 32'(memReq), 1);
    chk("R6", "addr held", 32'(memAddr), 32'(pa));
    while (!opDone) @(negedge clk);
    chk("R4", "pop 1 LIFO", 32'(popData), 32'h3333);
    chk("R3", "pop addr", 32'(pa), 32'h100F8);
    chk("R3", "ptr after pop", 32'(stackPtr), 32'h00FA);
    memLat = 0;
    doPop(v, pa);
    chk("R4", "pop 2 LIFO", 32'(v), 32'h2222);
    doPop(v, pa);
    chk("R4", "pop 3 LIFO", 32'(v), 32'h1111);

    // R8 conflict
    @(negedge clk); pushReq = 1; popReq = 1;
    @(negedge clk); pushReq = 0; popReq = 0;
    chk("R8", "conflict flag", 32'(errConflict), 1);
    chk("R8", "no request", 32'(memReq), 0);
    chk("R8", "ptr unchanged", 32'(stackPtr), 32'h00FE);
    @(negedge clk);
    chk("R8", "flag one cycle", 32'(errConflict), 0);

    // R9 load wins over push
    @(negedge clk); ldPtrValid = 1; ldPtrData = 16'h0200; pushReq = 1; pushData = 16'hDEAD;
    @(negedge clk); ldPtrValid = 0; pushReq = 0;
    chk("R9", "load priority ptr", 32'(stackPtr), 32'h0200);
    chk("R9", "push dropped", 32'(memReq), 0);

    // R9 load ignored while busy
    memLat = 3;
    @(negedge clk); popReq = 1;
    @(negedge clk); popReq = 0; ldPtrValid = 1; ldPtrData = 16'h5555; ldSegValid = 1; ldSegData = 16'h7777;
    @(negedge clk); ldPtrValid = 0; ldSegValid = 0;
    while (!opDone) @(negedge clk);
    chk("R9", "busy load ignored ptr", 32'(stackPtr), 32'h0202);
    chk("R9", "busy load ignored seg", 32'(stackSeg), 32'h1000);

    // R5 offset wrap
    memLat = 1;
    loadRegs(1, 16'h2000, 1, 16'h0000);
    doPush(16'hBEEF, a0);
    chk("R5", "wrap push addr", 32'(a0), 32'h2FFFE);
    chk("R5", "wrap push ptr", 32'(stackPtr), 32'hFFFE);
    doPop(v, pa);
    chk("R5", "wrap pop ptr", 32'(stackPtr), 32'h0000);
    chk("R5", "wrap pop data", 32'(v), 32'hBEEF);

    // R5 physical wrap
    loadRegs(1, 16'hFFFF, 1, 16'h0022);
    memLat = 0;
    doPush(16'hC0DE, a0);
    chk("R5", "phys wrap push", 32'(a0), 32'h00010);
    doPop(v, pa);
    chk("R5", "phys wrap pop addr", 32'(pa), 32'h00010);
    chk("R5", "phys wrap pop data", 32'(v), 32'hC0DE);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule